// File: doc/BRIEF.md
# Multi-Conference Summing Engine

This block is the arithmetic core of a conference bridge working on a time-slotted frame of linear voice samples. Each channel of the frame is set up as a member of one of several conferences, as a transparent pass-through, or as disconnected. During its own slot, a conference member hears the running total of its conference minus its own contribution. In the same slot, the sample it sent one frame earlier is taken out of that total and replaced by its new sample. Every conference total therefore always covers exactly one frame of samples from its members.

A per-conference status bit records that a total went past the accumulator range. It stays set until software clears it. A per-slot active-low strobe flags output slots whose conference is in that state. A frame-synchronous tone can replace the conference audio for the members that asked for it. Companding, serial framing and the processor bus sit outside the block. A surrounding sequencer presents one slot per cycle together with its index and a frame marker, and writes per-channel settings in idle cycles.

Top module: `conf_sum_engine`

## Requirements
- R1: After reset, out_valid is 0, ovf_n is 1, ovf_status is all zero and every channel is disconnected, so the first frame's outputs are all 0.
- R2: In a slot of a channel in conference mode (cfg_mode 1) with no tone, out_sample equals the sum of the latest samples of all other members of that conference, saturated to the signed SAMP_W-bit range.
- R3: A member's sample stays in its conference total from its own slot until the same slot of the next frame, where it is replaced by the new sample; a member that leaves or moves has its last sample removed from the old conference in its next slot.
- R4: In a slot of a channel in transparent mode (cfg_mode 2), out_sample equals that channel's sample from the previous frame, and the sample is never added to any conference.
- R5: A disconnected channel (cfg_mode 0) outputs 0 and adds nothing to any total.
- R6: The output is registered: one cycle after a slot with slot_valid high, out_valid is 1 and out_slot holds that slot index; after a cycle without a slot, out_valid is 0 and ovf_n is 1.
- R7: Each conference total is a signed ACC_W-bit saturating accumulator. A result past either limit sets that conference's bit in ovf_status. The bit stays set until a cycle with stat_clr high clears all bits, and a new overflow in the same cycle as a clear wins.
- R8: ovf_n is 0 with the output of a conference member whose conference status bit is set once that slot's update is included; otherwise it is 1.
- R9: When the frame's sampled tone-duration is high, a conference member whose tone bit is set outputs +T if the sampled tone-frequency is high and -T if it is low, where T = floor((2^(SAMP_W-1)-1)/10).
- R10: tone_dur and tone_freq are sampled only in the slot marked by frame_start, and that sample applies to that slot and the rest of the frame; changes at other times have no effect.
- R11: A configuration write with cfg_start high and cfg_mode 1 clears the total and the status bit of conference cfg_conf.
- R12: A configuration write (cfg_we) for a channel takes effect from that channel's next slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_valid | input | 1 | A slot is presented this cycle |
| frame_start | input | 1 | This slot is the first slot of a frame |
| slot_idx | input | CH_W | Channel index of the slot |
| sample_in | input | SAMP_W | Signed linear input sample |
| tone_dur | input | 1 | Tone enable, sampled at frame start |
| tone_freq | input | 1 | Square-wave tone polarity, sampled at frame start |
| cfg_we | input | 1 | Write the configuration of one channel |
| cfg_chan | input | CH_W | Channel being configured |
| cfg_mode | input | 2 | 0 disconnected, 1 conference, 2 transparent |
| cfg_conf | input | CONF_W | Conference number |
| cfg_tone | input | 1 | Tone insertion allowed for this channel |
| cfg_start | input | 1 | Clear this conference's total |
| stat_clr | input | 1 | Clear all overflow status bits |
| out_valid | output | 1 | Output slot valid |
| out_slot | output | CH_W | Channel index of the output |
| out_sample | output | SAMP_W | Signed linear output sample |
| ovf_n | output | 1 | Active-low overflow strobe for this output slot |
| ovf_status | output | N_CONF | Sticky overflow bit per conference |

## Verification
The bench builds the engine with 8 channels, 3 conferences and a 16-bit accumulator. With these values, five full-scale members already drive a total past its limit. That brings saturation, sticky status and the strobe within reach in one frame. The short frame also lets forty random frames exercise many leave, move and join sequences across conferences.

// File: rtl/conf_sum_pkg.sv
package conf_sum_pkg;
  typedef enum logic [1:0] {
    CH_OFF  = 2'd0,
    CH_CONF = 2'd1,
    CH_PASS = 2'd2
  } ch_mode_e;
endpackage

// File: rtl/conf_cfg_table.sv
module conf_cfg_table
  import conf_sum_pkg::*;
#(
  parameter int N_CHAN = 32,
  parameter int CH_W   = 5,
  parameter int CONF_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_chan,
  input  ch_mode_e          wr_mode,
  input  logic [CONF_W-1:0] wr_conf,
  input  logic              wr_tone,
  input  logic [CH_W-1:0]   rd_chan,
  output ch_mode_e          rd_mode,
  output logic [CONF_W-1:0] rd_conf,
  output logic              rd_tone
);
  ch_mode_e          mode_all [N_CHAN];
  logic [CONF_W-1:0] conf_all [N_CHAN];
  logic              tone_all [N_CHAN];

  for (genvar g = 0; g < N_CHAN; g++) begin : g_ent
    ch_mode_e          mode_q;
    logic [CONF_W-1:0] conf_q;
    logic              tone_q;
    logic              ent_en;

    assign ent_en = wr_en && (wr_chan == CH_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_q <= CH_OFF;
        conf_q <= '0;
        tone_q <= 1'b0;
      end else if (ent_en) begin
        mode_q <= wr_mode;
        conf_q <= wr_conf;
        tone_q <= wr_tone;
      end
    end

    assign mode_all[g] = mode_q;
    assign conf_all[g] = conf_q;
    assign tone_all[g] = tone_q;
  end

  always_comb begin
    rd_mode = CH_OFF;
    rd_conf = '0;
    rd_tone = 1'b0;
    for (int i = 0; i < N_CHAN; i++) begin
      if (rd_chan == CH_W'(i)) begin
        rd_mode = mode_all[i];
        rd_conf = conf_all[i];
        rd_tone = tone_all[i];
      end
    end
  end
endmodule

// File: rtl/conf_sample_hist.sv
module conf_sample_hist #(
  parameter int N_CHAN = 32,
  parameter int CH_W   = 5,
  parameter int CONF_W = 4,
  parameter int SAMP_W = 14
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [CH_W-1:0]          chan,
  input  logic signed [SAMP_W-1:0] wr_val,
  input  logic                     wr_added,
  input  logic [CONF_W-1:0]        wr_conf,
  output logic signed [SAMP_W-1:0] rd_val,
  output logic                     rd_added,
  output logic [CONF_W-1:0]        rd_conf
);
  logic signed [SAMP_W-1:0] val_all   [N_CHAN];
  logic                     added_all [N_CHAN];
  logic [CONF_W-1:0]        conf_all  [N_CHAN];

  for (genvar g = 0; g < N_CHAN; g++) begin : g_ent
    logic signed [SAMP_W-1:0] val_q;
    logic                     added_q;
    logic [CONF_W-1:0]        conf_q;
    logic                     ent_en;

    assign ent_en = wr_en && (chan == CH_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q   <= '0;
        added_q <= 1'b0;
        conf_q  <= '0;
      end else if (ent_en) begin
        val_q   <= wr_val;
        added_q <= wr_added;
        conf_q  <= wr_conf;
      end
    end

    assign val_all[g]   = val_q;
    assign added_all[g] = added_q;
    assign conf_all[g]  = conf_q;
  end

  always_comb begin
    rd_val   = '0;
    rd_added = 1'b0;
    rd_conf  = '0;
    for (int i = 0; i < N_CHAN; i++) begin
      if (chan == CH_W'(i)) begin
        rd_val   = val_all[i];
        rd_added = added_all[i];
        rd_conf  = conf_all[i];
      end
    end
  end
endmodule

// File: rtl/conf_acc_bank.sv
module conf_acc_bank #(
  parameter int N_CONF = 10,
  parameter int CONF_W = 4,
  parameter int SAMP_W = 14,
  parameter int ACC_W  = 18
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rm_en,
  input  logic [CONF_W-1:0]        rm_conf,
  input  logic signed [SAMP_W-1:0] rm_val,
  input  logic                     ad_en,
  input  logic [CONF_W-1:0]        ad_conf,
  input  logic signed [SAMP_W-1:0] ad_val,
  input  logic                     clr_en,
  input  logic [CONF_W-1:0]        clr_conf,
  input  logic                     stat_clr,
  input  logic [CONF_W-1:0]        rd_conf,
  output logic signed [ACC_W-1:0]  rd_acc,
  output logic                     rd_stat_d,
  output logic [N_CONF-1:0]        stat_q_o
);
  localparam int SW = ACC_W + 2;
  localparam logic signed [SW-1:0] AMAX = SW'((64'sd1 <<< (ACC_W - 1)) - 64'sd1);
  localparam logic signed [SW-1:0] AMIN = ~AMAX;

  logic signed [ACC_W-1:0] acc_all [N_CONF];
  logic [N_CONF-1:0]       stat_d_all;

  for (genvar i = 0; i < N_CONF; i++) begin : g_conf
    logic signed [ACC_W-1:0] acc_q, acc_d;
    logic                    st_q, st_d;
    logic signed [SW-1:0]    sum_w;
    logic                    rm_hit, ad_hit, clr_hit, hi, lo, acc_en;

    assign rm_hit  = rm_en  && (rm_conf  == CONF_W'(i));
    assign ad_hit  = ad_en  && (ad_conf  == CONF_W'(i));
    assign clr_hit = clr_en && (clr_conf == CONF_W'(i));
    assign acc_en  = rm_hit || ad_hit || clr_hit;

    always_comb begin
      sum_w = SW'(acc_q);
      if (rm_hit) sum_w = sum_w - SW'(rm_val);
      if (ad_hit) sum_w = sum_w + SW'(ad_val);
      hi = sum_w > AMAX;
      lo = sum_w < AMIN;
      if (clr_hit)  acc_d = '0;
      else if (hi)  acc_d = AMAX[ACC_W-1:0];
      else if (lo)  acc_d = AMIN[ACC_W-1:0];
      else          acc_d = sum_w[ACC_W-1:0];
      if (clr_hit)  st_d = 1'b0;
      else          st_d = (st_q && !stat_clr) || hi || lo;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q <= '0;
        st_q  <= 1'b0;
      end else begin
        if (acc_en) acc_q <= acc_d;
        st_q <= st_d;
      end
    end

    assign acc_all[i]    = acc_q;
    assign stat_d_all[i] = st_d;
    assign stat_q_o[i]   = st_q;
  end

  always_comb begin
    rd_acc    = '0;
    rd_stat_d = 1'b0;
    for (int i = 0; i < N_CONF; i++) begin
      if (rd_conf == CONF_W'(i)) begin
        rd_acc    = acc_all[i];
        rd_stat_d = stat_d_all[i];
      end
    end
  end
endmodule

// File: rtl/conf_sum_engine.sv
module conf_sum_engine
  import conf_sum_pkg::*;
#(
  parameter int N_CHAN = 32,
  parameter int N_CONF = 10,
  parameter int SAMP_W = 14,
  parameter int ACC_W  = 18,
  localparam int CH_W   = (N_CHAN > 1) ? $clog2(N_CHAN) : 1,
  localparam int CONF_W = (N_CONF > 1) ? $clog2(N_CONF) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     slot_valid,
  input  logic                     frame_start,
  input  logic [CH_W-1:0]          slot_idx,
  input  logic signed [SAMP_W-1:0] sample_in,
  input  logic                     tone_dur,
  input  logic                     tone_freq,
  input  logic                     cfg_we,
  input  logic [CH_W-1:0]          cfg_chan,
  input  logic [1:0]               cfg_mode,
  input  logic [CONF_W-1:0]        cfg_conf,
  input  logic                     cfg_tone,
  input  logic                     cfg_start,
  input  logic                     stat_clr,
  output logic                     out_valid,
  output logic [CH_W-1:0]          out_slot,
  output logic signed [SAMP_W-1:0] out_sample,
  output logic                     ovf_n,
  output logic [N_CONF-1:0]        ovf_status
);
  localparam int OW = ACC_W + 1;
  localparam logic signed [OW-1:0] SMAX_O = OW'((64'sd1 <<< (SAMP_W - 1)) - 64'sd1);
  localparam logic signed [OW-1:0] SMIN_O = ~SMAX_O;
  localparam logic signed [SAMP_W-1:0] TONE_P = SAMP_W'(((64'sd1 <<< (SAMP_W - 1)) - 64'sd1) / 64'sd10);

  ch_mode_e                ch_mode;
  logic [CONF_W-1:0]       ch_conf, h_conf;
  logic                    ch_tone, h_added, is_conf, own_hit, clr_en, stat_d_sel;
  logic signed [SAMP_W-1:0] h_val;
  logic signed [ACC_W-1:0]  acc_sel;
  logic signed [OW-1:0]     own_v, others;
  logic                    td_q, tf_q, td_eff, tf_eff;
  logic                    out_valid_d, ovf_n_d;
  logic signed [SAMP_W-1:0] out_sample_d, sat_others;

  conf_cfg_table #(.N_CHAN(N_CHAN), .CH_W(CH_W), .CONF_W(CONF_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_chan(cfg_chan),
    .wr_mode(ch_mode_e'(cfg_mode)), .wr_conf(cfg_conf), .wr_tone(cfg_tone),
    .rd_chan(slot_idx), .rd_mode(ch_mode), .rd_conf(ch_conf), .rd_tone(ch_tone)
  );

  assign is_conf = slot_valid && (ch_mode == CH_CONF);
  assign clr_en  = cfg_we && cfg_start && (ch_mode_e'(cfg_mode) == CH_CONF);

  conf_sample_hist #(.N_CHAN(N_CHAN), .CH_W(CH_W), .CONF_W(CONF_W), .SAMP_W(SAMP_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .wr_en(slot_valid), .chan(slot_idx),
    .wr_val(sample_in), .wr_added(is_conf), .wr_conf(ch_conf),
    .rd_val(h_val), .rd_added(h_added), .rd_conf(h_conf)
  );

  conf_acc_bank #(.N_CONF(N_CONF), .CONF_W(CONF_W), .SAMP_W(SAMP_W), .ACC_W(ACC_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .rm_en(slot_valid && h_added), .rm_conf(h_conf), .rm_val(h_val),
    .ad_en(is_conf), .ad_conf(ch_conf), .ad_val(sample_in),
    .clr_en(clr_en), .clr_conf(cfg_conf), .stat_clr(stat_clr),
    .rd_conf(ch_conf), .rd_acc(acc_sel), .rd_stat_d(stat_d_sel), .stat_q_o(ovf_status)
  );

  // tone controls held for the whole frame
  assign td_eff = (slot_valid && frame_start) ? tone_dur  : td_q;
  assign tf_eff = (slot_valid && frame_start) ? tone_freq : tf_q;

  always_comb begin
    own_hit = h_added && (h_conf == ch_conf);
    own_v   = own_hit ? OW'(h_val) : OW'(0);
    others  = OW'(acc_sel) - own_v;
    if (others > SMAX_O)      sat_others = SMAX_O[SAMP_W-1:0];
    else if (others < SMIN_O) sat_others = SMIN_O[SAMP_W-1:0];
    else                      sat_others = others[SAMP_W-1:0];
    case (ch_mode)
      CH_CONF: begin
        if (td_eff && ch_tone) out_sample_d = tf_eff ? TONE_P : -TONE_P;
        else                   out_sample_d = sat_others;
      end
      CH_PASS: out_sample_d = h_val;
      default: out_sample_d = '0;
    endcase
    out_valid_d = slot_valid;
    ovf_n_d     = !(is_conf && stat_d_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      td_q <= 1'b0;
      tf_q <= 1'b0;
    end else if (slot_valid && frame_start) begin
      td_q <= tone_dur;
      tf_q <= tone_freq;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      ovf_n      <= 1'b1;
      out_slot   <= '0;
      out_sample <= '0;
    end else begin
      out_valid <= out_valid_d;
      ovf_n     <= ovf_n_d;
      if (slot_valid) begin
        out_slot   <= slot_idx;
        out_sample <= out_sample_d;
      end
    end
  end
endmodule

// File: rtl/conf_sum_engine_chk.sv
module conf_sum_engine_chk #(
  parameter int CH_W   = 5,
  parameter int N_CONF = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              slot_valid,
  input logic [CH_W-1:0]   slot_idx,
  input logic              cfg_we,
  input logic              cfg_start,
  input logic              stat_clr,
  input logic              out_valid,
  input logic [CH_W-1:0]   out_slot,
  input logic              ovf_n,
  input logic [N_CONF-1:0] ovf_status
);
  // R6
  out_valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_valid |=> out_valid);

  // R6
  out_slot_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_valid |=> (out_slot == $past(slot_idx)));

  // R6
  idle_strobe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ovf_n);

  // R7
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_clr && !(cfg_we && cfg_start)) |=> ((ovf_status & $past(ovf_status)) == $past(ovf_status)));

  // R8
  strobe_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !ovf_n) |-> (ovf_status != '0));
endmodule

bind conf_sum_engine conf_sum_engine_chk #(.CH_W(CH_W), .N_CONF(N_CONF)) chk_i (
  .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_idx(slot_idx),
  .cfg_we(cfg_we), .cfg_start(cfg_start), .stat_clr(stat_clr),
  .out_valid(out_valid), .out_slot(out_slot), .ovf_n(ovf_n), .ovf_status(ovf_status)
);

// File: tb/conf_sum_engine_tb_top.sv
module conf_sum_engine_tb_top;
  localparam int NCH = 8;
  localparam int NCF = 3;
  localparam int SW  = 14;
  localparam int AW  = 16;
  localparam int CHW = 3;
  localparam int CFW = 2;
  localparam int SMAX = 8191;
  localparam int SMIN = -8192;
  localparam int AMAX = 32767;
  localparam int AMIN = -32768;
  localparam int TONE = 819;

  logic clk = 1'b0;
  logic rst_n;
  logic slot_valid, frame_start, tone_dur, tone_freq;
  logic [CHW-1:0] slot_idx, cfg_chan, out_slot;
  logic signed [SW-1:0] sample_in, out_sample;
  logic cfg_we, cfg_tone, cfg_start, stat_clr, out_valid, ovf_n;
  logic [1:0] cfg_mode;
  logic [CFW-1:0] cfg_conf;
  logic [NCF-1:0] ovf_status;

  always #4 clk = ~clk;

  conf_sum_engine #(.N_CHAN(NCH), .N_CONF(NCF), .SAMP_W(SW), .ACC_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .frame_start(frame_start),
    .slot_idx(slot_idx), .sample_in(sample_in), .tone_dur(tone_dur), .tone_freq(tone_freq),
    .cfg_we(cfg_we), .cfg_chan(cfg_chan), .cfg_mode(cfg_mode), .cfg_conf(cfg_conf),
    .cfg_tone(cfg_tone), .cfg_start(cfg_start), .stat_clr(stat_clr),
    .out_valid(out_valid), .out_slot(out_slot), .out_sample(out_sample),
    .ovf_n(ovf_n), .ovf_status(ovf_status)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference state
  int acc[NCF];
  bit mst[NCF];
  int hist[NCH];
  bit added[NCH];
  int aconf[NCH];
  int mmode[NCH];
  int mconf[NCH];
  bit mtone[NCH];
  bit lt_dur, lt_freq;
  int xs[NCH];

  function automatic int sat_s(int v);
    if (v > SMAX) return SMAX;
    if (v < SMIN) return SMIN;
    return v;
  endfunction

  function automatic logic [NCF-1:0] st_vec();
    logic [NCF-1:0] v;
    for (int i = 0; i < NCF; i++) v[i] = mst[i];
    return v;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic slot(int k, int x, bit fs, bit td, bit tf, string tag);
    int ed, ef, m, c, own, oth, d, expv;
    bit expn;
    string rt;
    slot_valid = 1; slot_idx = CHW'(k); sample_in = SW'(x);
    frame_start = fs; tone_dur = td; tone_freq = tf;
    ed = fs ? td : lt_dur;
    ef = fs ? tf : lt_freq;
    if (fs) begin lt_dur = td; lt_freq = tf; end
    m = mmode[k]; c = mconf[k];
    own = (added[k] && aconf[k] == c) ? hist[k] : 0;
    oth = acc[c] - own;
    for (int i = 0; i < NCF; i++) begin
      d = acc[i];
      if (added[k] && aconf[k] == i) d -= hist[k];
      if (m == 1 && c == i) d += x;
      if (d > AMAX) begin acc[i] = AMAX; mst[i] = 1; end
      else if (d < AMIN) begin acc[i] = AMIN; mst[i] = 1; end
      else acc[i] = d;
    end
    if (m == 1) begin
      if (ed != 0 && mtone[k]) begin expv = (ef != 0) ? TONE : -TONE; rt = "R9"; end
      else begin expv = sat_s(oth); rt = "R2"; end
    end else if (m == 2) begin expv = hist[k]; rt = "R4"; end
    else begin expv = 0; rt = "R5"; end
    expn = !(m == 1 && mst[c]);
    hist[k] = x; added[k] = (m == 1); aconf[k] = c;
    @(negedge clk);
    check({"R6 out_valid ", tag}, int'(out_valid), 1);
    check({"R6 out_slot ", tag}, int'(out_slot), k);
    check({rt, " out_sample ch", $sformatf("%0d ", k), tag}, int'(out_sample), expv);
    check({"R8 ovf_n ", tag}, int'(ovf_n), int'(expn));
    check({"R7 ovf_status ", tag}, int'(ovf_status), int'(st_vec()));
  endtask

  task automatic idle(bit clr);
    slot_valid = 0; frame_start = 0; stat_clr = clr;
    if (clr) for (int i = 0; i < NCF; i++) mst[i] = 0;
    @(negedge clk);
    stat_clr = 0;
    check("R6 idle out_valid", int'(out_valid), 0);
    check("R6 idle ovf_n", int'(ovf_n), 1);
    check("R7 ovf_status after idle", int'(ovf_status), int'(st_vec()));
  endtask

  task automatic cfg(int ch, int md, int cf, bit tn, bit st);
    slot_valid = 0; frame_start = 0;
    cfg_we = 1; cfg_chan = CHW'(ch); cfg_mode = 2'(md); cfg_conf = CFW'(cf);
    cfg_tone = tn; cfg_start = st;
    mmode[ch] = md; mconf[ch] = cf; mtone[ch] = tn;
    if (st && md == 1) begin acc[cf] = 0; mst[cf] = 0; end
    @(negedge clk);
    cfg_we = 0; cfg_start = 0;
  endtask

  task automatic frame(bit td, bit tf, bit td_mid, string tag);
    for (int k = 0; k < NCH; k++)
      slot(k, xs[k], k == 0, (k == 0) ? td : td_mid, (k == 0) ? tf : ~tf, tag);
    idle(0);
  endtask

  function automatic int rnd_samp();
    int r = int'($urandom % 4);
    if (r == 0) return SMAX;
    if (r == 1) return SMIN;
    return int'($urandom_range(0, 16383)) - 8192;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(1234));
    for (int i = 0; i < NCF; i++) begin acc[i] = 0; mst[i] = 0; end
    for (int i = 0; i < NCH; i++) begin
      hist[i] = 0; added[i] = 0; aconf[i] = 0; mmode[i] = 0; mconf[i] = 0; mtone[i] = 0;
    end
    lt_dur = 0; lt_freq = 0;
    rst_n = 0; slot_valid = 0; frame_start = 0; slot_idx = '0; sample_in = '0;
    tone_dur = 0; tone_freq = 0; cfg_we = 0; cfg_chan = '0; cfg_mode = '0;
    cfg_conf = '0; cfg_tone = 0; cfg_start = 0; stat_clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 ovf_n", int'(ovf_n), 1);
    check("R1 ovf_status", int'(ovf_status), 0);
    for (int k = 0; k < NCH; k++) xs[k] = 1000 + k;
    frame(0, 0, 0, "R1 all off");

    // R11 start clears, R12 takes effect next slot, R2/R3 conference, R4 transparent, R5 off
    cfg(0, 1, 0, 0, 1);
    cfg(1, 1, 0, 0, 0);
    cfg(2, 1, 0, 0, 0);
    cfg(3, 2, 0, 0, 0);
    for (int f = 0; f < 3; f++) begin
      for (int k = 0; k < NCH; k++) xs[k] = (k + 1) * 100 * (f + 1) - 50 * k;
      frame(0, 0, 0, "R3 R12 directed");
    end
    // R3: channel 1 leaves, its last sample leaves the total in its next slot
    cfg(1, 0, 0, 0, 0);
    frame(0, 0, 0, "R3 leave");
    frame(0, 0, 0, "R3 after leave");

    // R7 R8 overflow with five full-scale members in conference 2
    cfg(0, 1, 2, 0, 1);
    for (int k = 1; k < 5; k++) cfg(k, 1, 2, 0, 0);
    for (int k = 0; k < NCH; k++) xs[k] = (k < 5) ? SMAX : -5;
    frame(0, 0, 0, "R7 overflow");
    frame(0, 0, 0, "R7 sticky");
    idle(1);   // R7 clear
    check("R7 cleared", int'(ovf_status), 0);
    cfg(0, 1, 2, 0, 1);  // R11 restart conference 2
    check("R11 status cleared", int'(ovf_status), int'(st_vec()));
    for (int k = 0; k < NCH; k++) xs[k] = -SMAX + k;
    frame(0, 0, 0, "R11 R7 negative");

    // R9 R10 tone
    for (int k = 0; k < 4; k++) cfg(k, 1, 1, k != 3, k == 0);
    for (int k = 0; k < NCH; k++) xs[k] = 300 * k - 700;
    frame(1, 1, 0, "R9 R10 tone high mid-frame drop");
    frame(1, 0, 1, "R9 R10 tone negative");
    frame(0, 1, 1, "R10 tone off at start");

    // random phase
    for (int f = 0; f < 40; f++) begin
      if ($urandom % 3 == 0)
        for (int j = 0; j < 2; j++)
          cfg(int'($urandom % NCH), int'($urandom % 3), int'($urandom % NCF),
              bit'($urandom % 2), ($urandom % 10) == 0);
      for (int k = 0; k < NCH; k++) xs[k] = rnd_samp();
      for (int k = 0; k < NCH; k++)
        slot(k, xs[k], k == 0, bit'($urandom % 2), bit'($urandom % 2), "random");
      idle(($urandom % 8) == 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule